// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns the addressing fields of an instruction operand into an operand address. It takes a 3-bit mode, a 3-bit register number, an operand size and a flag that says whether the operand will be written. Two combinational read ports fetch the values it needs. One port reads the base address register. The other reads the index register, where numbers 0 to 7 select data registers and 8 to 15 select address registers.

Extension words come from the instruction stream on a 32-bit window. The first word sits in bits 31:16 and the second in bits 15:0. The unit also receives the address of that first extension word. It does not fetch the words itself.

One cycle after a request, the unit presents its result and raises a valid flag. The result holds the operand address, any address-register writeback for the stepping modes, the number of extension bytes used and an illegal flag. For immediate operands no address is produced; the immediate value is passed through instead.

Top module: `ea_calc`

## Requirements
- R1: Mode 2 gives the selected address register as the address. Modes 0 and 1 (register direct) give address 0. Neither uses extension bytes or a writeback.
- R2: Mode 3 (post-increment) gives the current address register as the address. It writes back that value plus the step. The step is 1 for size 0 (byte), 2 for size 1 (word), and 4 for sizes 2 (long) and 3 (treated as long).
- R3: Mode 4 (pre-decrement) subtracts the step from the register. Both the address and the writeback take the reduced value.
- R4: For a byte-size operand on register 7, modes 3 and 4 use a step of 2.
- R5: Mode 5 adds the sign-extended first extension word to the address register and uses 2 extension bytes.
- R6: Mode 6 forms the address as base + sign-extended bits 7:0 + index. The index register number is in bits 15:12 of the first extension word. Bit 11 set selects the full 32-bit index; bit 11 clear selects the sign-extended low 16 bits. This mode uses 2 extension bytes.
- R7: Mode 7 register field selects a sub-mode. Sub-mode 0 is a sign-extended absolute word (2 bytes). Sub-mode 1 is an absolute long from the full window (4 bytes). Sub-mode 2 is pc_i plus the sign-extended first word (2 bytes). Sub-mode 3 is indexed as in R6 with pc_i as the base (2 bytes).
- R8: Sub-mode 4 is immediate data, flagged on imm_o, with address 0. A byte immediate is bits 23:16 of the window, zero-extended, using 2 bytes. A word immediate is bits 31:16 (2 bytes). A long immediate is all 32 bits (4 bytes).
- R9: When modify_i is clear, sub-modes 0 to 4 are legal. When modify_i is set, only sub-modes 0 and 1 are legal. Any other sub-mode raises illegal_o and gives address 0, 0 extension bytes and no writeback.
- R10: Results and valid_o appear on the first rising edge after req_i is high. valid_o is low after any edge without a request. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Compute request |
| mode_i | input | 3 | Addressing mode |
| reg_i | input | 3 | Register field or mode 7 sub-mode |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| modify_i | input | 1 | Operand is a destination that is written |
| pc_i | input | 32 | Address of the first extension word |
| ext_i | input | 32 | Extension window, first word in bits 31:16 |
| ar_idx_o | output | 3 | Base address-register read index |
| ar_data_i | input | 32 | Base address-register read data |
| xr_idx_o | output | 4 | Index register read index (0-7 data, 8-15 address) |
| xr_data_i | input | 32 | Index register read data |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Address-register writeback enable |
| wb_idx_o | output | 3 | Writeback register number |
| wb_data_o | output | 32 | Writeback value |
| ext_bytes_o | output | 3 | Extension bytes used |
| illegal_o | output | 1 | Illegal mode encoding |
| imm_o | output | 1 | Operand is immediate |
| imm_data_o | output | 32 | Immediate value |

## Verification
The bench targets the byte step on register 7. A unit that missed this rule would leave the stack pointer odd, with a difference of 1 instead of 2.

The index vectors use a data register whose word and long values differ. An inverted or ignored bit 11 therefore gives a different address. Another vector uses a negative byte displacement with an address-register index; a unit that dropped sign extension would land 256 bytes away.

Destination operands in sub-modes 2 to 4 must be rejected while the same sub-modes are accepted for reads. A shared legality check would pass one case and fail the other. A byte immediate must come from the low half of the first word, so a unit that took the high byte would show the wrong value.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } ea_size_e;

  localparam logic [2:0] M_DREG = 3'd0;
  localparam logic [2:0] M_AREG = 3'd1;
  localparam logic [2:0] M_IND  = 3'd2;
  localparam logic [2:0] M_PINC = 3'd3;
  localparam logic [2:0] M_PDEC = 3'd4;
  localparam logic [2:0] M_DISP = 3'd5;
  localparam logic [2:0] M_IDX  = 3'd6;
  localparam logic [2:0] M_EXT  = 3'd7;

  localparam logic [2:0] X_ABSW = 3'd0;
  localparam logic [2:0] X_ABSL = 3'd1;
  localparam logic [2:0] X_PCD  = 3'd2;
  localparam logic [2:0] X_PCX  = 3'd3;
  localparam logic [2:0] X_IMM  = 3'd4;

  localparam logic [2:0] SP_NUM = 3'd7;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] sext8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction
endpackage

// File: rtl/ea_step.sv
module ea_step
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    size_i,
  input  logic [2:0]    reg_i,
  output logic [AW-1:0] step_o
);
  logic [2:0] step_n;

  always_comb begin
    unique case (ea_size_e'(size_i))
      SZ_BYTE: step_n = (reg_i == SP_NUM) ? 3'd2 : 3'd1;
      SZ_WORD: step_n = 3'd2;
      default: step_n = 3'd4;
    endcase
  end

  assign step_o = {{(AW-3){1'b0}}, step_n};

  always_comb begin
    // R4
    sp_even_chk: assert (!(reg_i == SP_NUM) || step_o[0] == 1'b0);
  end
endmodule

// File: rtl/ea_index.sv
module ea_index
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int XW = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [15:0]   brief_i,
  output logic [XW-1:0] xr_idx_o,
  input  logic [AW-1:0] xr_data_i,
  output logic [AW-1:0] addr_o
);
  localparam int XSEL_LO = 16 - XW;
  localparam int LONG_BIT = 11;

  logic [AW-1:0] idx_val;
  logic [AW-1:0] disp;

  assign xr_idx_o = brief_i[15:XSEL_LO];
  assign idx_val  = brief_i[LONG_BIT] ? xr_data_i : AW'(sext16(xr_data_i[15:0]));
  assign disp     = AW'(sext8(brief_i[7:0]));
  assign addr_o   = base_i + disp + idx_val;
endmodule

// File: rtl/ea_mode7.sv
module ea_mode7
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int BW = 3
) (
  input  logic [2:0]    sub_i,
  input  logic [1:0]    size_i,
  input  logic          modify_i,
  input  logic [31:0]   ext_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] idx_addr_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bytes_o,
  output logic          ill_o,
  output logic          imm_o,
  output logic [31:0]   imm_data_o
);
  logic legal;

  always_comb begin
    if (modify_i) legal = (sub_i == X_ABSW) || (sub_i == X_ABSL);
    else          legal = (sub_i <= X_IMM);
  end

  always_comb begin
    addr_o     = '0;
    bytes_o    = '0;
    imm_o      = 1'b0;
    imm_data_o = '0;
    ill_o      = !legal;
    if (legal) begin
      unique case (sub_i)
        X_ABSW: begin addr_o = AW'(sext16(ext_i[31:16])); bytes_o = BW'(2); end
        X_ABSL: begin addr_o = AW'(ext_i);                bytes_o = BW'(4); end
        X_PCD:  begin addr_o = pc_i + AW'(sext16(ext_i[31:16])); bytes_o = BW'(2); end
        X_PCX:  begin addr_o = idx_addr_i; bytes_o = BW'(2); end
        default: begin
          imm_o = 1'b1;
          unique case (ea_size_e'(size_i))
            SZ_BYTE: begin imm_data_o = {24'd0, ext_i[23:16]}; bytes_o = BW'(2); end
            SZ_WORD: begin imm_data_o = {16'd0, ext_i[31:16]}; bytes_o = BW'(2); end
            default: begin imm_data_o = ext_i;                 bytes_o = BW'(4); end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int XW = 4,
  parameter int BW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    reg_i,
  input  logic [1:0]    size_i,
  input  logic          modify_i,
  input  logic [AW-1:0] pc_i,
  input  logic [31:0]   ext_i,
  output logic [2:0]    ar_idx_o,
  input  logic [AW-1:0] ar_data_i,
  output logic [XW-1:0] xr_idx_o,
  input  logic [AW-1:0] xr_data_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [2:0]    wb_idx_o,
  output logic [AW-1:0] wb_data_o,
  output logic [BW-1:0] ext_bytes_o,
  output logic          illegal_o,
  output logic          imm_o,
  output logic [31:0]   imm_data_o
);
  logic [AW-1:0] step, idx_base, idx_addr;
  logic [AW-1:0] m7_addr;
  logic [BW-1:0] m7_bytes;
  logic          m7_ill, m7_imm;
  logic [31:0]   m7_imm_data;

  logic [AW-1:0] addr_n, wb_n;
  logic [BW-1:0] bytes_n;
  logic          wb_en_n, ill_n, imm_n;
  logic [31:0]   imm_data_n;

  assign ar_idx_o = reg_i;
  assign idx_base = (mode_i == M_EXT) ? pc_i : ar_data_i;

  ea_step #(.AW(AW)) u_step (
    .size_i(size_i), .reg_i(reg_i), .step_o(step)
  );

  ea_index #(.AW(AW), .XW(XW)) u_index (
    .base_i(idx_base), .brief_i(ext_i[31:16]),
    .xr_idx_o(xr_idx_o), .xr_data_i(xr_data_i), .addr_o(idx_addr)
  );

  ea_mode7 #(.AW(AW), .BW(BW)) u_mode7 (
    .sub_i(reg_i), .size_i(size_i), .modify_i(modify_i), .ext_i(ext_i),
    .pc_i(pc_i), .idx_addr_i(idx_addr), .addr_o(m7_addr), .bytes_o(m7_bytes),
    .ill_o(m7_ill), .imm_o(m7_imm), .imm_data_o(m7_imm_data)
  );

  always_comb begin
    addr_n     = '0;
    wb_n       = '0;
    wb_en_n    = 1'b0;
    bytes_n    = '0;
    ill_n      = 1'b0;
    imm_n      = 1'b0;
    imm_data_n = '0;
    unique case (mode_i)
      M_DREG, M_AREG: ;
      M_IND:  addr_n = ar_data_i;
      M_PINC: begin addr_n = ar_data_i; wb_n = ar_data_i + step; wb_en_n = 1'b1; end
      M_PDEC: begin addr_n = ar_data_i - step; wb_n = ar_data_i - step; wb_en_n = 1'b1; end
      M_DISP: begin addr_n = ar_data_i + AW'(sext16(ext_i[31:16])); bytes_n = BW'(2); end
      M_IDX:  begin addr_n = idx_addr; bytes_n = BW'(2); end
      default: begin
        addr_n     = m7_addr;
        bytes_n    = m7_bytes;
        ill_n      = m7_ill;
        imm_n      = m7_imm;
        imm_data_n = m7_imm_data;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      addr_o      <= '0;
      wb_en_o     <= 1'b0;
      wb_idx_o    <= '0;
      wb_data_o   <= '0;
      ext_bytes_o <= '0;
      illegal_o   <= 1'b0;
      imm_o       <= 1'b0;
      imm_data_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        addr_o      <= addr_n;
        wb_en_o     <= wb_en_n;
        wb_idx_o    <= reg_i;
        wb_data_o   <= wb_n;
        ext_bytes_o <= bytes_n;
        illegal_o   <= ill_n;
        imm_o       <= imm_n;
        imm_data_o  <= imm_data_n;
      end
    end
  end

  // R10
  req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  // R10
  idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R3
  predec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == M_PDEC) |=> (wb_en_o && wb_data_o == addr_o));
  // R4
  sp_byte_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == M_PINC && reg_i == SP_NUM && size_i == 2'd0)
      |=> (wb_data_o - addr_o == AW'(2)));
  // R9
  modify_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && modify_i && mode_i == M_EXT && reg_i > X_ABSL) |=> illegal_o);
  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (addr_o == '0 && ext_bytes_o == '0 && !wb_en_o));
endmodule

// File: tb/sim_ea_calc.sv
module sim_ea_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0, reg_i = '0;
  logic [1:0]  size_i = '0;
  logic        modify_i = 1'b0;
  logic [31:0] pc_i = 32'h0000_4000;
  logic [31:0] ext_i = '0;
  logic [2:0]  ar_idx_o;
  logic [31:0] ar_data_i;
  logic [3:0]  xr_idx_o;
  logic [31:0] xr_data_i;
  logic        valid_o, wb_en_o, illegal_o, imm_o;
  logic [31:0] addr_o, wb_data_o, imm_data_o;
  logic [2:0]  wb_idx_o, ext_bytes_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  ea_calc u0 (.*);

  // register file model: An = 0x1000_0000 + n*0x100, D3 = 0x0001_FFF0
  function automatic logic [31:0] areg(input logic [2:0] n);
    return 32'h1000_0000 + {21'd0, n, 8'd0};
  endfunction
  always_comb ar_data_i = areg(ar_idx_o);
  always_comb xr_data_i = xr_idx_o[3] ? areg(xr_idx_o[2:0])
                        : (xr_idx_o[2:0] == 3'd3 ? 32'h0001_FFF0 : 32'd0);

  typedef struct packed {
    logic [3:0]  tag;
    logic [2:0]  mode;
    logic [2:0]  rg;
    logic [1:0]  size;
    logic        modify;
    logic [31:0] ext;
    logic [31:0] addr;
    logic        wben;
    logic [31:0] wb;
    logic [2:0]  bytes;
    logic        ill;
    logic        imm;
    logic [31:0] immd;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd2, 3'd2, 2'd2, 1'b0, 32'h0, 32'h1000_0200, 1'b0, 32'h0, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd1, 3'd0, 3'd5, 2'd2, 1'b0, 32'h0, 32'h0,         1'b0, 32'h0, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd2, 3'd3, 3'd2, 2'd1, 1'b0, 32'h0, 32'h1000_0200, 1'b1, 32'h1000_0202, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd2, 3'd3, 3'd2, 2'd0, 1'b0, 32'h0, 32'h1000_0200, 1'b1, 32'h1000_0201, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd2, 3'd3, 3'd2, 2'd3, 1'b1, 32'h0, 32'h1000_0200, 1'b1, 32'h1000_0204, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd4, 3'd3, 3'd7, 2'd0, 1'b0, 32'h0, 32'h1000_0700, 1'b1, 32'h1000_0702, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd4, 3'd4, 3'd7, 2'd0, 1'b0, 32'h0, 32'h1000_06FE, 1'b1, 32'h1000_06FE, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd3, 3'd4, 3'd1, 2'd2, 1'b0, 32'h0, 32'h1000_00FC, 1'b1, 32'h1000_00FC, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd3, 3'd4, 3'd1, 2'd0, 1'b0, 32'h0, 32'h1000_00FF, 1'b1, 32'h1000_00FF, 3'd0, 1'b0, 1'b0, 32'h0},
    '{4'd5, 3'd5, 3'd2, 2'd1, 1'b0, 32'hFFFE_0000, 32'h1000_01FE, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd6, 3'd6, 3'd2, 2'd1, 1'b0, 32'h3004_0000, 32'h1000_01F4, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd6, 3'd6, 3'd2, 2'd1, 1'b0, 32'h3804_0000, 32'h1002_01F4, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd6, 3'd6, 3'd2, 2'd1, 1'b0, 32'h90F0_0000, 32'h1000_02F0, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd7, 3'd7, 3'd0, 2'd1, 1'b0, 32'h8000_0000, 32'hFFFF_8000, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd7, 3'd7, 3'd1, 2'd1, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, 32'h0, 3'd4, 1'b0, 1'b0, 32'h0},
    '{4'd7, 3'd7, 3'd2, 2'd1, 1'b0, 32'h0010_0000, 32'h0000_4010, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd7, 3'd7, 3'd3, 2'd1, 1'b0, 32'h3004_0000, 32'h0000_3FF4, 1'b0, 32'h0, 3'd2, 1'b0, 1'b0, 32'h0},
    '{4'd8, 3'd7, 3'd4, 2'd0, 1'b0, 32'hABCD_0000, 32'h0, 1'b0, 32'h0, 3'd2, 1'b0, 1'b1, 32'h0000_00CD},
    '{4'd8, 3'd7, 3'd4, 2'd1, 1'b0, 32'hABCD_0000, 32'h0, 1'b0, 32'h0, 3'd2, 1'b0, 1'b1, 32'h0000_ABCD},
    '{4'd8, 3'd7, 3'd4, 2'd2, 1'b0, 32'h1122_3344, 32'h0, 1'b0, 32'h0, 3'd4, 1'b0, 1'b1, 32'h1122_3344},
    '{4'd9, 3'd7, 3'd5, 2'd1, 1'b0, 32'h1234_5678, 32'h0, 1'b0, 32'h0, 3'd0, 1'b1, 1'b0, 32'h0},
    '{4'd9, 3'd7, 3'd2, 2'd1, 1'b1, 32'h0010_0000, 32'h0, 1'b0, 32'h0, 3'd0, 1'b1, 1'b0, 32'h0},
    '{4'd9, 3'd7, 3'd4, 2'd2, 1'b1, 32'h1122_3344, 32'h0, 1'b0, 32'h0, 3'd0, 1'b1, 1'b0, 32'h0},
    '{4'd9, 3'd7, 3'd1, 2'd2, 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b0, 32'h0, 3'd4, 1'b0, 1'b0, 32'h0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3";
      4'd4: return "R4"; 4'd5: return "R5"; 4'd6: return "R6";
      4'd7: return "R7"; 4'd8: return "R8"; default: return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R10: watchdog expired, actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", {valid_o, addr_o, wb_en_o, ext_bytes_o, illegal_o, imm_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10", {127'd0, valid_o}, '0);

    for (int i = 0; i < NV; i++) begin
      mode_i = VECS[i].mode; reg_i = VECS[i].rg; size_i = VECS[i].size;
      modify_i = VECS[i].modify; ext_i = VECS[i].ext; req_i = 1'b1;
      @(negedge clk_i);
      check(rname(VECS[i].tag),
            {valid_o, addr_o, wb_en_o, wb_en_o ? wb_data_o : 32'h0,
             ext_bytes_o, illegal_o, imm_o, imm_o ? imm_data_o : 32'h0},
            {1'b1, VECS[i].addr, VECS[i].wben, VECS[i].wb,
             VECS[i].bytes, VECS[i].ill, VECS[i].imm, VECS[i].immd});
      if (VECS[i].wben) check(rname(VECS[i].tag), {125'd0, wb_idx_o}, {125'd0, VECS[i].rg});
    end

    // R10 no request: valid drops, outputs hold
    req_i = 1'b0; mode_i = 3'd2; reg_i = 3'd3;
    @(negedge clk_i);
    check("R10", {valid_o, addr_o}, {1'b0, 32'h1234_5678});

    // R9 illegal after a stepping mode leaves no writeback
    mode_i = 3'd3; reg_i = 3'd1; size_i = 2'd1; modify_i = 1'b0; req_i = 1'b1;
    @(negedge clk_i);
    check("R2", {wb_en_o, wb_data_o}, {1'b1, 32'h1000_0102});
    mode_i = 3'd7; reg_i = 3'd7;
    @(negedge clk_i);
    check("R9", {illegal_o, wb_en_o, addr_o, ext_bytes_o}, {1'b1, 1'b0, 32'h0, 3'd0});

    // R10 reset mid-stream clears outputs
    req_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R10", {valid_o, illegal_o, addr_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule